// File: doc/BRIEF.md
# Banked Auxiliary Memory Controller with Unlock Command Channel

This block holds the bank-select state of an auxiliary memory expansion that sits on an 8-bit CPU bus. The CPU reaches it through a single write-only I/O register. Every byte written there becomes the new bank number. The output bank number is that register ANDed with a capacity mask, so a smaller memory fitted behind the block folds onto the banks it really has.

The same stream of bank writes also carries a hidden command channel. A fixed six-byte unlock pattern opens it. The write after the pattern is taken as a command code, and the write after that as the command's argument. One command sets the capacity mask. A second turns on or off an activity LED, which flashes on every auxiliary-memory access. A third command leaves the bank register at all ones in place of the argument, so software can tell this block apart from a plain bank card.

Two things drop a partial sequence: an idle timeout, and two zero writes in a row.

Top module: `auxbank_ctrl`

## Requirements
- R1: Every write with `bank_wr` high loads `bank_wdata` into the bank register, and `bank_sel` shows it from the next cycle on. The one exception is R5. After reset the bank register is 0x00, the mask is 0xFF and the LED enable is 1.
- R2: The unlock pattern is the bytes 0xFF, 0x00, 0x55, 0xAA, 0xC1, 0xAD on consecutive register writes. The write after a full pattern is the command byte and the next write is the argument, whatever their values. The sequence then returns to idle.
- R3: The command 0xE0 copies its argument into the capacity mask. `bank_sel` always equals the bank register ANDed with the mask.
- R4: The command 0xE2 copies bit 0 of its argument into the LED enable.
- R5: The command 0xFF makes its argument write load 0xFF into the bank register, in place of the argument value.
- R6: During the unlock pattern, a byte that does not match sends the sequence to idle. If that byte is 0xFF, it counts as the first pattern byte instead.
- R7: Two consecutive writes of 0x00 return the sequence to idle from any state.
- R8: A write is still accepted when it comes TMO_CYCLES clock edges after the previous write, and this holds even in the cycle where the timeout expires. If no write arrives for that many edges, the sequence returns to idle, so a write one edge later starts from idle.
- R9: While the LED enable is 1, an `aux_access` pulse drives `led_out` high for exactly LED_PULSE_CYC cycles. A new access restarts the count. While the enable is 0, `led_out` stays low.
- R10: With the mask at 0xFF, `bank_sel` can take all 256 values from 0x00 to 0xFF.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bank_wr | input | 1 | One-cycle strobe: the CPU writes the bank register |
| bank_wdata | input | 8 | Byte written by the CPU |
| aux_access | input | 1 | One-cycle strobe: an auxiliary-memory access took place |
| bank_sel | output | 8 | Effective bank number (bank register AND capacity mask) |
| led_out | output | 1 | Activity LED drive |

## Verification
The timeout expiry and an arriving register write can fall on the same clock edge. The rule is that the write wins and is judged against the sequence state it found. The bench provokes this by spacing a command byte after the unlock pattern by exactly TMO_CYCLES edges, and then by one edge more. Whether the command took effect is judged by whether the capacity mask then changes `bank_sel`. The reference model in the bench tracks the time since the last write in its own way and compares both outputs on every cycle.

// File: rtl/auxbank_pkg.sv
// auxbank_pkg
// Shared constants for the banked auxiliary memory controller: command codes
// and the unlock pattern. Assumes an 8-bit CPU data bus.
package auxbank_pkg;

    localparam int          UNLOCK_LEN    = 6;
    localparam logic [7:0]  CMD_SET_MASK  = 8'hE0;
    localparam logic [7:0]  CMD_SET_LED   = 8'hE2;
    localparam logic [7:0]  CMD_FORCE_TOP = 8'hFF;

    // Returns the expected byte at a given position of the unlock pattern.
    function automatic logic [7:0] unlock_byte(input int idx);
        case (idx)
            0:       unlock_byte = 8'hFF;
            1:       unlock_byte = 8'h00;
            2:       unlock_byte = 8'h55;
            3:       unlock_byte = 8'hAA;
            4:       unlock_byte = 8'hC1;
            5:       unlock_byte = 8'hAD;
            default: unlock_byte = 8'h00;
        endcase
    endfunction

endpackage

// File: rtl/auxbank_timeout.sv
// auxbank_timeout
// Idle timer for the command sequence. Reloads to LIMIT on every register
// write and counts down while the sequence is away from idle. Raises expire
// in the cycle it would reach zero without a write. A write in that same
// cycle takes priority and reloads the timer.
// Assumes LIMIT >= 1 and that LIMIT fits in CNT_W bits.
module auxbank_timeout #(
    parameter int unsigned CNT_W = 16,
    parameter int unsigned LIMIT = 65535
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    input  logic armed,
    output logic expire
);
    localparam logic [CNT_W-1:0] LOAD = CNT_W'(LIMIT);
    localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

    logic [CNT_W-1:0] cnt_q;

    // Reload on write, count down while armed, stop at zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (restart) begin
            cnt_q <= LOAD;
        end else if (armed && cnt_q != '0) begin
            cnt_q <= cnt_q - ONE;
        end
    end

    // Expiry: last count while armed, with no write in the same cycle.
    assign expire = armed && !restart && (cnt_q == ONE);

    // R8: a sequence away from idle always has time left on the timer.
    a_r8_armed_has_time: assert property (@(posedge clk) disable iff (!rst_n)
        armed |-> (cnt_q != '0));

    // R8: the timer never exceeds its load value.
    a_r8_count_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LOAD);

endmodule

// File: rtl/auxbank_seq.sv
// auxbank_seq
// Tracks the unlock pattern, the command byte and the argument byte on the
// bank write stream. Raises cmd_fire for one cycle on the argument write,
// with cmd_code holding the latched command.
// Assumes a one-cycle wr_en strobe per CPU write.
module auxbank_seq
    import auxbank_pkg::*;
#(
    parameter int PAT_LEN = UNLOCK_LEN
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    input  logic       tmo_expire,
    output logic       armed,
    output logic       cmd_fire,
    output logic [7:0] cmd_code
);
    localparam int                POS_W   = $clog2(PAT_LEN + 2);
    localparam int                HIT_N   = 2 ** POS_W;
    localparam logic [POS_W-1:0]  CMD_POS = POS_W'(PAT_LEN);
    localparam logic [POS_W-1:0]  ARG_POS = POS_W'(PAT_LEN + 1);
    localparam logic [POS_W-1:0]  POS_ONE = POS_W'(1);

    logic [POS_W-1:0] pos_q, pos_d;
    logic             last_zero_q;
    logic [7:0]       cmd_q;
    logic [HIT_N-1:0] hit_ext;
    logic             zero_pair;
    logic             restart_hit;
    logic             fire;

    // One comparator per pattern position; unused positions never match.
    for (genvar gi = 0; gi < HIT_N; gi++) begin : g_hit
        if (gi < PAT_LEN) begin : g_cmp
            assign hit_ext[gi] = (wr_data == unlock_byte(gi));
        end else begin : g_pad
            assign hit_ext[gi] = 1'b0;
        end
    end

    assign zero_pair   = last_zero_q && (wr_data == 8'h00);
    assign restart_hit = (wr_data == unlock_byte(0));

    // Next sequence position and the command strobe.
    always_comb begin
        pos_d = pos_q;
        fire  = 1'b0;
        if (wr_en) begin
            if (zero_pair) begin
                pos_d = '0;
            end else if (pos_q < CMD_POS) begin
                if (hit_ext[pos_q]) begin
                    pos_d = pos_q + POS_ONE;
                end else if (restart_hit) begin
                    pos_d = POS_ONE;
                end else begin
                    pos_d = '0;
                end
            end else if (pos_q == CMD_POS) begin
                pos_d = ARG_POS;
            end else begin
                fire  = 1'b1;
                pos_d = '0;
            end
        end else if (tmo_expire) begin
            pos_d = '0;
        end
    end

    // Sequence state, zero-write history and the latched command byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos_q       <= '0;
            last_zero_q <= 1'b0;
            cmd_q       <= '0;
        end else begin
            pos_q <= pos_d;
            if (wr_en) begin
                last_zero_q <= (wr_data == 8'h00);
            end
            if (wr_en && pos_q == CMD_POS) begin
                cmd_q <= wr_data;
            end
        end
    end

    assign armed    = (pos_q != '0);
    assign cmd_fire = fire;
    assign cmd_code = cmd_q;

    // R7: two zero writes in a row leave the tracker idle.
    a_r7_zero_pair_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_data == 8'h00 && last_zero_q) |=> (pos_q == '0));

    // R8: timeout expiry returns the tracker to idle.
    a_r8_timeout_idle: assert property (@(posedge clk) disable iff (!rst_n)
        tmo_expire |=> (pos_q == '0));

    // R2: a write in the command slot always moves on to the argument slot.
    a_r2_cmd_advances: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && pos_q == CMD_POS && !zero_pair) |=> (pos_q == ARG_POS));

    // R2: the command strobe only comes with a register write.
    a_r2_fire_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_fire |-> wr_en);

endmodule

// File: rtl/auxbank_led.sv
// auxbank_led
// Activity LED stretcher. Each trigger seen while enabled loads a counter
// with PULSE. The LED is lit while the counter is nonzero and enable is set.
// Assumes PULSE >= 1 and that PULSE fits in CNT_W bits.
module auxbank_led #(
    parameter int unsigned CNT_W = 11,
    parameter int unsigned PULSE = 1024
) (
    input  logic clk,
    input  logic rst_n,
    input  logic trig,
    input  logic en,
    output logic led
);
    localparam logic [CNT_W-1:0] LOAD = CNT_W'(PULSE);
    localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

    logic [CNT_W-1:0] cnt_q;
    logic             busy;

    // Load on an enabled trigger, otherwise count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (trig && en) begin
            cnt_q <= LOAD;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - ONE;
        end
    end

    assign busy = (cnt_q != '0);
    assign led  = en && busy;

    // R9: an enabled access starts a pulse on the next cycle.
    a_r9_pulse_starts: assert property (@(posedge clk) disable iff (!rst_n)
        (trig && en) |=> busy);

    // R9: the LED is dark whenever it is disabled.
    a_r9_dark_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        !en |-> !led);

endmodule

// File: rtl/auxbank_ctrl.sv
// auxbank_ctrl
// Top level of the banked auxiliary memory controller. It holds the bank,
// capacity-mask and LED-enable registers, and applies the commands decoded
// by auxbank_seq. The sequence timer and the LED stretcher are submodules.
// Assumes one-cycle strobes on bank_wr and aux_access.
module auxbank_ctrl
    import auxbank_pkg::*;
#(
    parameter int unsigned TMO_CYCLES    = 65535,
    parameter int unsigned LED_PULSE_CYC = 1024
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bank_wr,
    input  logic [7:0] bank_wdata,
    input  logic       aux_access,
    output logic [7:0] bank_sel,
    output logic       led_out
);
    localparam int unsigned TMO_W = $clog2(TMO_CYCLES + 1);
    localparam int unsigned LED_W = $clog2(LED_PULSE_CYC + 1);

    logic [7:0] bank_q;
    logic [7:0] mask_q;
    logic       led_en_q;
    logic       armed;
    logic       tmo_expire;
    logic       cmd_fire;
    logic [7:0] cmd_code;
    logic       force_top;

    auxbank_seq #(
        .PAT_LEN (UNLOCK_LEN)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (bank_wr),
        .wr_data    (bank_wdata),
        .tmo_expire (tmo_expire),
        .armed      (armed),
        .cmd_fire   (cmd_fire),
        .cmd_code   (cmd_code)
    );

    auxbank_timeout #(
        .CNT_W (TMO_W),
        .LIMIT (TMO_CYCLES)
    ) u_tmo (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (bank_wr),
        .armed   (armed),
        .expire  (tmo_expire)
    );

    auxbank_led #(
        .CNT_W (LED_W),
        .PULSE (LED_PULSE_CYC)
    ) u_led (
        .clk   (clk),
        .rst_n (rst_n),
        .trig  (aux_access),
        .en    (led_en_q),
        .led   (led_out)
    );

    assign force_top = cmd_fire && (cmd_code == CMD_FORCE_TOP);

    // Bank register: loads every write; the forcing command sets all ones.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bank_q <= 8'h00;
        end else if (bank_wr) begin
            bank_q <= force_top ? 8'hFF : bank_wdata;
        end
    end

    // Capacity mask and LED enable: updated only by their commands.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q   <= 8'hFF;
            led_en_q <= 1'b1;
        end else if (cmd_fire) begin
            if (cmd_code == CMD_SET_MASK) begin
                mask_q <= bank_wdata;
            end
            if (cmd_code == CMD_SET_LED) begin
                led_en_q <= bank_wdata[0];
            end
        end
    end

    assign bank_sel = bank_q & mask_q;

    // R1: after a write the bank holds the written byte or the forced value.
    a_r1_write_loads: assert property (@(posedge clk) disable iff (!rst_n)
        bank_wr |=> (bank_q == $past(bank_wdata) || bank_q == 8'hFF));

    // R3: without a register write the effective bank does not move.
    a_r3_sel_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !bank_wr |=> $stable(bank_sel));

    // R5: the forcing command leaves all ones in the bank register.
    a_r5_force_top: assert property (@(posedge clk) disable iff (!rst_n)
        force_top |=> (bank_q == 8'hFF));

    // R4: the LED enable only changes on a command strobe.
    a_r4_led_en_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_fire |=> $stable(led_en_q));

endmodule

// File: tb/auxbank_ctrl_tb.sv
`timescale 1ns/1ps
module auxbank_ctrl_tb;
    localparam int T = 20;
    localparam int P = 5;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bank_wr = 1'b0;
    logic [7:0] bank_wdata = 8'h00;
    logic       aux_access = 1'b0;
    logic [7:0] bank_sel;
    logic       led_out;

    always #2 clk = ~clk;

    auxbank_ctrl #(.TMO_CYCLES(T), .LED_PULSE_CYC(P)) u_dut (
        .clk(clk), .rst_n(rst_n), .bank_wr(bank_wr), .bank_wdata(bank_wdata),
        .aux_access(aux_access), .bank_sel(bank_sel), .led_out(led_out)
    );

    int    vectors = 0;
    int    fails = 0;
    string cur_req = "R1";
    bit    started = 1'b0;
    bit    finished = 1'b0;

    // Reference model state
    int m_bank, m_mask, m_leden, m_pos, m_cmd, m_lastzero, m_since, m_led_left;
    int pat[6] = '{255, 0, 85, 170, 193, 173};

    // Behavioural reference, advanced on every rising edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_bank = 0; m_mask = 255; m_leden = 1; m_pos = 0; m_cmd = 0;
            m_lastzero = 0; m_since = 0; m_led_left = 0;
        end else begin
            int  d;
            bit  fire;
            d = int'(bank_wdata);
            if (aux_access && m_leden == 1) m_led_left = P;
            else if (m_led_left > 0) m_led_left--;
            if (bank_wr) begin
                fire = 1'b0;
                if (m_lastzero == 1 && d == 0) m_pos = 0;
                else if (m_pos < 6) begin
                    if (d == pat[m_pos]) m_pos++;
                    else if (d == 255) m_pos = 1;
                    else m_pos = 0;
                end else if (m_pos == 6) begin
                    m_cmd = d; m_pos = 7;
                end else begin
                    fire = 1'b1; m_pos = 0;
                end
                m_bank = (fire && m_cmd == 255) ? 255 : d;
                if (fire && m_cmd == 224) m_mask = d;
                if (fire && m_cmd == 226) m_leden = d % 2;
                m_lastzero = (d == 0) ? 1 : 0;
                m_since = 0;
            end else begin
                if (m_since < 1000000) m_since++;
                if (m_since >= T) m_pos = 0;
            end
        end
    end

    // Cycle-by-cycle comparison against the model.
    always @(negedge clk) begin
        if (started && !finished) begin
            vectors++;
            if (bank_sel !== 8'(m_bank & m_mask)) begin
                fails++;
                $display("FAIL %s model bank_sel: actual %02h expected %02h",
                         cur_req, bank_sel, 8'(m_bank & m_mask));
            end
            if (led_out !== (m_leden == 1 && m_led_left > 0)) begin
                fails++;
                $display("FAIL %s model led_out: actual %0b expected %0b",
                         cur_req, led_out, (m_leden == 1 && m_led_left > 0));
            end
        end
    end

    task automatic step(input bit we, input logic [7:0] d, input bit acc);
        @(negedge clk);
        bank_wr = we; bank_wdata = d; aux_access = acc;
    endtask

    task automatic wr(input logic [7:0] d);
        step(1'b1, d, 1'b0);
    endtask

    task automatic nop();
        step(1'b0, 8'h00, 1'b0);
    endtask

    task automatic chk(input string req, input logic [7:0] exp_sel, input bit exp_led);
        vectors++;
        if (bank_sel !== exp_sel || led_out !== exp_led) begin
            fails++;
            $display("FAIL %s direct: actual sel=%02h led=%0b expected sel=%02h led=%0b",
                     req, bank_sel, led_out, exp_sel, exp_led);
        end
    endtask

    task automatic unlock();
        for (int i = 0; i < 6; i++) wr(8'(pat[i]));
    endtask

    task automatic command(input logic [7:0] c, input logic [7:0] a);
        wr(8'h00); wr(8'h00);
        unlock(); wr(c); wr(a);
    endtask

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            fails++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        started = 1'b1;
        // R1: reset state
        chk("R1", 8'h00, 1'b0);

        // R1: plain writes
        cur_req = "R1";
        wr(8'h12); nop(); chk("R1", 8'h12, 1'b0);
        wr(8'h37); nop(); chk("R1", 8'h37, 1'b0);

        // R10: every bank code reachable
        cur_req = "R10";
        for (int v = 0; v < 256; v++) begin
            wr(8'(v)); nop(); chk("R10", 8'(v), 1'b0);
        end

        // R3: capacity mask
        cur_req = "R3";
        command(8'hE0, 8'h0F); nop(); chk("R3", 8'h0F, 1'b0);
        wr(8'h3C); nop(); chk("R3", 8'h0C, 1'b0);

        // R5: forcing command under a mask, then with a full mask
        cur_req = "R5";
        command(8'hE0, 8'h3F);
        command(8'hFF, 8'h00); nop(); chk("R5", 8'h3F, 1'b0);
        command(8'hE0, 8'hFF);
        command(8'hFF, 8'h42); nop(); chk("R5", 8'hFF, 1'b0);
        // R2: a non-command value in the command slot leaves the argument visible
        cur_req = "R2";
        command(8'h17, 8'h42); nop(); chk("R2", 8'h42, 1'b0);

        // R4/R9: LED disabled by an even argument
        cur_req = "R4";
        command(8'hE2, 8'hFE);
        step(1'b0, 8'h00, 1'b1); nop(); chk("R4", 8'hFE, 1'b0);
        command(8'hE2, 8'h03);
        cur_req = "R9";
        step(1'b0, 8'h00, 1'b1);
        nop(); chk("R9", 8'h03, 1'b1);
        repeat (P - 1) nop();
        chk("R9", 8'h03, 1'b1);
        nop(); chk("R9", 8'h03, 1'b0);
        // R9: retrigger restarts the count
        step(1'b0, 8'h00, 1'b1);
        repeat (3) nop();
        step(1'b0, 8'h00, 1'b1);
        repeat (P) nop();
        chk("R9", 8'h03, 1'b1);
        nop(); chk("R9", 8'h03, 1'b0);

        // R6: wrong byte aborts the sequence
        cur_req = "R6";
        wr(8'h00); wr(8'h00);
        wr(8'hFF); wr(8'h00); wr(8'h55); wr(8'h12);
        wr(8'hAA); wr(8'hC1); wr(8'hAD); wr(8'hE0); wr(8'h01);
        wr(8'h80); nop(); chk("R6", 8'h80, 1'b0);
        // R6: a stray 0xFF restarts the pattern
        wr(8'h00); wr(8'h00);
        wr(8'hFF); wr(8'h00); wr(8'h55); wr(8'hFF);
        wr(8'h00); wr(8'h55); wr(8'hAA); wr(8'hC1); wr(8'hAD); wr(8'hE0); wr(8'h07);
        wr(8'hFF); nop(); chk("R6", 8'h07, 1'b0);
        command(8'hE0, 8'hFF);

        // R7: a zero pair mid-pattern drops it
        cur_req = "R7";
        wr(8'hFF); wr(8'h00); wr(8'h55); wr(8'hAA); wr(8'hC1);
        wr(8'h00); wr(8'h00);
        wr(8'hAD); wr(8'hE0); wr(8'h01);
        wr(8'h96); nop(); chk("R7", 8'h96, 1'b0);

        // R8: command byte exactly T edges later is accepted (collides with expiry)
        cur_req = "R8";
        wr(8'h00); wr(8'h00);
        unlock();
        repeat (T - 1) nop();
        wr(8'hE0); wr(8'h1F);
        wr(8'hF0); nop(); chk("R8", 8'h10, 1'b0);
        command(8'hE0, 8'hFF);
        // R8: one edge later the sequence has timed out
        wr(8'h00); wr(8'h00);
        unlock();
        repeat (T) nop();
        wr(8'hE0); wr(8'h1F);
        wr(8'hF0); nop(); chk("R8", 8'hF0, 1'b0);

        repeat (4) nop();
        finished = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule